// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Timer

This block is a 16-bit up/down counter that produces two centre-aligned pulse-width modulated outputs. The counter climbs from zero to a ceiling value, turns, descends back to zero and repeats. Each of the two channels compares the count against its own threshold. On the way up a match drives the output to one level, and on the way down a match drives it back. The waveform is therefore symmetric about the ceiling, which suits motor and power-stage control.

Software sets the block up through a small write port that holds four words: a control word, a ceiling register and two compare thresholds. The control word selects the clock divider, the source of the ceiling, the output behaviour of each channel and the update mode. Thresholds and the ceiling register are double-buffered. In the top-reload mode, new values take effect when the counter turns at the ceiling. In the bottom-reload mode, they take effect when it turns at zero, so both halves of every period use the same settings. While the divider is stopped, writes take effect at once.

The counter sequencer has three states. After reset it sits in ST_HOLD at zero. The first tick moves it to ST_RISE, and it counts up. A tick in ST_RISE with the count at or above the ceiling moves it to ST_FALL, and it counts down. A tick in ST_FALL with the count at zero moves it back to ST_RISE.

Top module: `sympwm_timer`

## Requirements
- R1: After reset, both PWM outputs and both event strobes are low. While the divider field is 0 (stopped), no strobe ever fires.
- R2: The count visits 0, 1, …, TOP, TOP−1, …, 1, 0 and repeats. Each turning value is held for one tick only. With a divider of 1, successive top and bottom strobes are TOP cycles apart.
- R3: `top_evt` is high for one cycle, on the tick at which the count equals TOP. `bot_evt` is high for one cycle, on the tick at which the count equals 0 while descending. After a top strobe the count is TOP−1, and after a bottom strobe it is 1.
- R4: Control bits [10:8] select the divider: 1, 2, 3, 4 and 5 give ticks every 1, 8, 64, 256 and 1024 clocks, and 0 stops the counter. With divider N, strobe spacing is N·TOP clocks and the output period is 2·N·TOP clocks.
- R5: Channel mode code 2 (non-inverting; channel A is control bits [5:4], channel B is bits [7:6]) drives the output low on an up-count match and high on a down-count match. For 0 < C < TOP the output is high for C ticks in each half period.
- R6: Channel mode code 3 (inverting) swaps those levels, so the output is high for TOP−C ticks in each half period.
- R7: A threshold of 0 holds the output at the inactive level (low when non-inverting). A threshold equal to TOP holds it at the active level (high when non-inverting).
- R8: A threshold above TOP never matches, and the output keeps its previous level.
- R9: When channel A supplies the ceiling and uses mode code 1, output A toggles at every top turn: it is high for 2·TOP ticks, then low for 2·TOP ticks. Mode code 0, and code 1 on any channel where toggling does not apply, keep that output low.
- R10: Control bits [3:1] choose the ceiling source: 0, 1 and 2 select fixed 0x00FF, 0x01FF and 0x03FF; 3 selects the ceiling register (address 1); 4 selects channel A's threshold.
- R11: When a fixed ceiling is selected, a threshold write (address 2 for channel A, address 3 for channel B) has its bits above the fixed width cleared.
- R12: With control bit 0 cleared (top reload), buffered values load on the tick that leaves TOP. The descent after a ceiling change therefore spans the old TOP, and the following ascent spans the new one.
- R13: With control bit 0 set (bottom reload), buffered ceiling and threshold values load on the tick that leaves 0, so both halves of the next period use them.
- R14: Writes made while the divider field is 0 take effect immediately, without waiting for a reload point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 ceiling, 2 threshold A, 3 threshold B |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| top_evt | output | 1 | One-cycle strobe on the tick at the ceiling |
| bot_evt | output | 1 | One-cycle strobe on the tick at zero |

## Verification
The turn at the ceiling and the reload of buffered values happen on the same clock edge in top-reload mode. The turn has to be decided with the old ceiling while the new one is already being loaded. The bench provokes this by rewriting the ceiling just after a top strobe. It then judges the spacing of the following strobes: the next descent and ascent must stay at the old length, and the ascent after that must stretch. The same stimulus in bottom-reload mode must instead move the new ceiling and threshold together into the ascent right after the next bottom strobe.

// File: rtl/sympwm_pkg.sv
package sympwm_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 10;
    localparam int N_CH   = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_TOP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP0 = 2'd2;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } slope_e;

    typedef enum logic [2:0] {
        TS_FIX8  = 3'd0,
        TS_FIX9  = 3'd1,
        TS_FIX10 = 3'd2,
        TS_REG   = 3'd3,
        TS_CMPA  = 3'd4
    } top_src_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic [2:0] clk_sel;
        out_mode_e  mode_b;
        out_mode_e  mode_a;
        top_src_e   top_src;
        logic       pfc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic src_is_fixed(top_src_e s);
        return (s != TS_REG) && (s != TS_CMPA);
    endfunction

    function automatic logic [CNT_W-1:0] fixed_top(top_src_e s);
        case (s)
            TS_FIX9:  return CNT_W'(16'h01FF);
            TS_FIX10: return CNT_W'(16'h03FF);
            default:  return CNT_W'(16'h00FF);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] pick_top(top_src_e s,
                                                  logic [CNT_W-1:0] reg_v,
                                                  logic [CNT_W-1:0] cmpa_v);
        case (s)
            TS_REG:  return reg_v;
            TS_CMPA: return cmpa_v;
            default: return fixed_top(s);
        endcase
    endfunction

    function automatic logic [PRE_W-1:0] presc_mask(logic [2:0] sel);
        case (sel)
            3'd2:    return PRE_W'(7);
            3'd3:    return PRE_W'(63);
            3'd4:    return PRE_W'(255);
            3'd5:    return PRE_W'(1023);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sympwm_prescale.sv
module sympwm_prescale
    import sympwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;
    logic             wrap;

    assign mask = presc_mask(sel);
    assign wrap = ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (sel == 3'd0) begin
            div_q <= '0;
        end else if (wrap) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PRE_W'(1);
        end
    end

    assign tick = (sel != 3'd0) && wrap;

endmodule

// File: rtl/sympwm_regs.sv
module sympwm_regs
    import sympwm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic                        load,
    output ctrl_t                       ctrl,
    output logic [CNT_W-1:0]            top_cur,
    output logic [CNT_W-1:0]            top_use,
    output logic [N_CH-1:0][CNT_W-1:0]  cmp_use
);

    ctrl_t                      ctrl_q;
    logic [CNT_W-1:0]           top_buf;
    logic [CNT_W-1:0]           top_act;
    logic [N_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [N_CH-1:0][CNT_W-1:0] cmp_act;
    logic                       stopped;
    logic [CNT_W-1:0]           wmask;

    assign stopped = (ctrl_q.clk_sel == 3'd0);
    assign wmask   = src_is_fixed(ctrl_q.top_src) ? fixed_top(ctrl_q.top_src) : '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_buf <= '0;
            top_act <= '0;
        end else begin
            if (load) begin
                top_act <= top_buf;
            end
            if (wr_en && wr_addr == A_TOP) begin
                top_buf <= wr_data;
                if (stopped) begin
                    top_act <= wr_data;
                end
            end
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = A_CMP0 + ADDR_W'(c);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_buf[c] <= '0;
                cmp_act[c] <= '0;
            end else begin
                if (load) begin
                    cmp_act[c] <= cmp_buf[c];
                end
                if (wr_en && wr_addr == MY_ADDR) begin
                    cmp_buf[c] <= wr_data & wmask;
                    if (stopped) begin
                        cmp_act[c] <= wr_data & wmask;
                    end
                end
            end
        end

        assign cmp_use[c] = load ? cmp_buf[c] : cmp_act[c];
    end

    assign ctrl    = ctrl_q;
    assign top_cur = pick_top(ctrl_q.top_src, top_act, cmp_act[0]);
    assign top_use = load ? pick_top(ctrl_q.top_src, top_buf, cmp_buf[0]) : top_cur;

endmodule

// File: rtl/sympwm_counter.sv
module sympwm_counter
    import sympwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pfc,
    input  logic [CNT_W-1:0] top_cur,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             rise_nxt,
    output logic             top_evt,
    output logic             bot_evt,
    output logic             load
);

    slope_e           st_q;
    slope_e           st_d;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (tick) begin
            unique case (st_q)
                ST_HOLD: begin
                    st_d  = ST_RISE;
                    cnt_d = cnt_q + CNT_W'(1);
                end
                ST_RISE: begin
                    if (cnt_q >= top_cur) begin
                        st_d  = ST_FALL;
                        cnt_d = cnt_q - CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_FALL: begin
                    if (cnt_q == '0) begin
                        st_d  = ST_RISE;
                        cnt_d = cnt_q + CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        top_evt  = tick && (st_q == ST_RISE) && (cnt_q >= top_cur);
        bot_evt  = tick && (st_q == ST_FALL) && (cnt_q == '0);
        load     = pfc ? bot_evt : top_evt;
        cnt_nxt  = cnt_d;
        rise_nxt = (st_d == ST_RISE);
    end

endmodule

// File: rtl/sympwm_chan.sv
module sympwm_chan
    import sympwm_pkg::*;
#(
    parameter bit ALLOW_TOGGLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  out_mode_e        mode,
    input  logic             src_is_me,
    input  logic [CNT_W-1:0] cmp_use,
    input  logic [CNT_W-1:0] top_use,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             rise_nxt,
    input  logic             top_evt,
    output logic             pwm
);

    logic oc_q;
    logic toggle_en;
    logic pwm_en;
    logic inv;

    assign toggle_en = ALLOW_TOGGLE && (mode == OM_TOGGLE) && src_is_me;
    assign pwm_en    = (mode == OM_NONINV) || (mode == OM_INV);
    assign inv       = (mode == OM_INV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q <= 1'b0;
        end else if (tick) begin
            if (toggle_en) begin
                if (top_evt) begin
                    oc_q <= ~oc_q;
                end
            end else if (pwm_en) begin
                if (cmp_use == '0) begin
                    oc_q <= inv;
                end else if (cmp_use == top_use) begin
                    oc_q <= ~inv;
                end else if (cnt_nxt == cmp_use) begin
                    oc_q <= rise_nxt ? inv : ~inv;
                end
            end
        end
    end

    assign pwm = (pwm_en || toggle_en) ? oc_q : 1'b0;

endmodule

// File: rtl/sympwm_timer.sv
module sympwm_timer
    import sympwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              top_evt,
    output logic              bot_evt
);

    ctrl_t                      ctrl_q;
    logic                       tick;
    logic                       load;
    logic [CNT_W-1:0]           top_cur;
    logic [CNT_W-1:0]           top_use;
    logic [N_CH-1:0][CNT_W-1:0] cmp_use;
    logic [CNT_W-1:0]           cnt_q;
    logic [CNT_W-1:0]           cnt_nxt;
    logic                       rise_nxt;
    logic [N_CH-1:0]            pwm_v;
    out_mode_e                  mode_v [N_CH];

    sympwm_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q.clk_sel),
        .tick  (tick)
    );

    sympwm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .ctrl    (ctrl_q),
        .top_cur (top_cur),
        .top_use (top_use),
        .cmp_use (cmp_use)
    );

    sympwm_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pfc      (ctrl_q.pfc),
        .top_cur  (top_cur),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .rise_nxt (rise_nxt),
        .top_evt  (top_evt),
        .bot_evt  (bot_evt),
        .load     (load)
    );

    assign mode_v[0] = ctrl_q.mode_a;
    assign mode_v[1] = ctrl_q.mode_b;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        sympwm_chan #(
            .ALLOW_TOGGLE (c == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .mode      (mode_v[c]),
            .src_is_me (ctrl_q.top_src == TS_CMPA),
            .cmp_use   (cmp_use[c]),
            .top_use   (top_use),
            .cnt_nxt   (cnt_nxt),
            .rise_nxt  (rise_nxt),
            .top_evt   (top_evt),
            .pwm       (pwm_v[c])
        );
    end

    assign pwm_a = pwm_v[0];
    assign pwm_b = pwm_v[1];

endmodule

// File: rtl/sympwm_chk.sv
module sympwm_chk
    import sympwm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [2:0]       clk_sel,
    input logic [CNT_W-1:0] cnt,
    input logic             top_evt,
    input logic             bot_evt,
    input logic             load,
    input out_mode_e        mode_a,
    input logic [CNT_W-1:0] cmpa,
    input logic             pwm_a
);

    // R4
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |-> !tick);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R3
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R3
    bot_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bot_evt |=> (cnt == CNT_W'(1)));

    // R3
    top_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt |=> !top_evt);

    // R7
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && mode_a == OM_NONINV && cmpa == '0) |=> !pwm_a);

endmodule

bind sympwm_timer sympwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clk_sel (ctrl_q.clk_sel),
    .cnt     (cnt_q),
    .top_evt (top_evt),
    .bot_evt (bot_evt),
    .load    (load),
    .mode_a  (ctrl_q.mode_a),
    .cmpa    (cmp_use[0]),
    .pwm_a   (pwm_a)
);

// File: tb/sympwm_timer_test.sv
module sympwm_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_a, pwm_b, top_evt, bot_evt;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit    end_top;
        int    len;
        int    ha;
        int    hb;
        string req;
    } seg_t;

    seg_t sbq[$];

    always #2 clk = ~clk;

    sympwm_timer uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b),
        .top_evt (top_evt),
        .bot_evt (bot_evt)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(int sel, int mb, int ma, int src, int pfc);
        return 16'((sel << 8) | (mb << 6) | (ma << 4) | (src << 1) | pfc);
    endfunction

    task automatic reg_wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_bot(int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!bot_evt);
        end
        #1;
    endtask

    task automatic wait_top();
        do @(negedge clk); while (!top_evt);
        #1;
    endtask

    task automatic push(bit et, int len, int ha, int hb, string req);
        seg_t s;
        s.end_top = et; s.len = len; s.ha = ha; s.hb = hb; s.req = req;
        sbq.push_back(s);
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // monitor: measures each stretch between strobes
    int  seg_len = 0, seg_a = 0, seg_b = 0;
    bit  seg_ok = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (top_evt || bot_evt)) begin
            if (seg_ok && sbq.size() > 0) begin
                seg_t e;
                e = sbq.pop_front();
                chk({e.req, " strobe kind"}, int'(top_evt), int'(e.end_top));
                chk({e.req, " length"}, seg_len, e.len);
                if (e.ha >= 0) chk({e.req, " high A"}, seg_a, e.ha);
                if (e.hb >= 0) chk({e.req, " high B"}, seg_b, e.hb);
            end
            seg_len = 1; seg_a = int'(pwm_a); seg_b = int'(pwm_b); seg_ok = 1'b1;
        end else begin
            seg_len++; seg_a += int'(pwm_a); seg_b += int'(pwm_b);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int strobes, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset while stopped
        strobes = 0; highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            strobes += int'(top_evt) + int'(bot_evt);
            highs   += int'(pwm_a) + int'(pwm_b);
        end
        chk("R1 strobes while stopped", strobes, 0);
        chk("R1 outputs after reset", highs, 0);

        // R14 R5 R6 R10 R2: TOP register 20, A=5 non-inverting, B=12 inverting
        reg_wr(2'd0, mk_ctrl(0, 3, 2, 3, 0));
        reg_wr(2'd1, 16'd20);
        reg_wr(2'd2, 16'd5);
        reg_wr(2'd3, 16'd12);
        reg_wr(2'd0, mk_ctrl(1, 3, 2, 3, 0));
        wait_bot(1);
        push(1, 20, 5, 8, "R14 R5 R6 rise");
        push(0, 20, 5, 8, "R2 R5 R6 fall");
        drain();

        // R7: A=0 non-inverting low, B=TOP non-inverting high
        reg_wr(2'd0, mk_ctrl(0, 2, 2, 3, 0));
        reg_wr(2'd2, 16'd0);
        reg_wr(2'd3, 16'd20);
        reg_wr(2'd0, mk_ctrl(1, 2, 2, 3, 0));
        wait_bot(2);
        push(1, 20, 0, 20, "R7 rise");
        push(0, 20, 0, 20, "R7 fall");
        drain();

        // R8: B above TOP keeps its level
        reg_wr(2'd3, 16'd25);
        wait_bot(3);
        push(1, 20, 0, 20, "R8 rise");
        push(0, 20, 0, 20, "R8 fall");
        drain();

        // R4: divider 8, TOP 10
        reg_wr(2'd0, mk_ctrl(0, 0, 2, 3, 0));
        reg_wr(2'd1, 16'd10);
        reg_wr(2'd2, 16'd3);
        reg_wr(2'd0, mk_ctrl(2, 0, 2, 3, 0));
        wait_bot(2);
        push(1, 80, -1, -1, "R4 rise");
        push(0, 80, -1, 0, "R4 R9 fall");
        drain();

        // R10 R11: fixed 8-bit ceiling, masked threshold
        reg_wr(2'd0, mk_ctrl(0, 0, 2, 0, 0));
        reg_wr(2'd2, 16'h1F05);
        reg_wr(2'd0, mk_ctrl(1, 0, 2, 0, 0));
        wait_bot(2);
        push(1, 255, 5, 0, "R10 R11 rise");
        push(0, 255, 5, 0, "R10 R11 fall");
        drain();

        // R12: top reload, ceiling raised during a descent
        reg_wr(2'd0, mk_ctrl(0, 0, 0, 3, 0));
        reg_wr(2'd1, 16'd20);
        reg_wr(2'd0, mk_ctrl(1, 0, 0, 3, 0));
        wait_bot(2);
        wait_top();
        push(0, 20, -1, -1, "R12 fall old");
        push(1, 20, -1, -1, "R12 rise old");
        push(0, 20, -1, -1, "R12 fall spans old");
        push(1, 30, -1, -1, "R12 rise new");
        push(0, 30, -1, -1, "R12 fall new");
        reg_wr(2'd1, 16'd30);
        drain();

        // R13: bottom reload, ceiling and threshold change together
        reg_wr(2'd0, mk_ctrl(0, 0, 2, 3, 1));
        reg_wr(2'd1, 16'd20);
        reg_wr(2'd2, 16'd5);
        reg_wr(2'd0, mk_ctrl(1, 0, 2, 3, 1));
        wait_bot(2);
        wait_top();
        push(0, 20, 5, -1, "R13 fall old");
        push(1, 30, 12, -1, "R13 rise new");
        push(0, 30, 12, -1, "R13 fall new");
        reg_wr(2'd1, 16'd30);
        reg_wr(2'd2, 16'd12);
        drain();

        // R9: toggle on A with A as ceiling, code 1 on B stays low
        begin
            logic prev;
            int   hi, lo, bseen;
            reg_wr(2'd0, mk_ctrl(0, 1, 1, 4, 0));
            reg_wr(2'd2, 16'd15);
            reg_wr(2'd0, mk_ctrl(1, 1, 1, 4, 0));
            wait_bot(2);
            bseen = 0;
            prev = pwm_a;
            do begin
                @(negedge clk);
                bseen += int'(pwm_b);
                if (pwm_a && !prev) break;
                prev = pwm_a;
            end while (1);
            hi = 0;
            do begin hi++; @(negedge clk); bseen += int'(pwm_b); end while (pwm_a);
            lo = 0;
            do begin lo++; @(negedge clk); bseen += int'(pwm_b); end while (!pwm_a);
            chk("R9 toggle high time", hi, 30);
            chk("R9 toggle low time", lo, 30);
            chk("R9 code 1 on B", bseen, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule